// File: doc/BRIEF.md
# Retirement-Ordered Watchpoint Generator

This block turns comparator match events into watchpoints. It first combines the events through a configurable AND-OR stage and then reports each watchpoint only when the instruction that raised it retires. Every event carries the tag of the in-flight instruction that caused it. Instruction-fetch events produce fetch watchpoints. Load/store address and data events produce load/store watchpoints. A load/store watchpoint can be made conditional on a fetch watchpoint that the same instruction raised.

Watchpoints that have been detected but not yet reported sit in a small table indexed by tag. Each entry is a sticky bit vector, so a watchpoint type that is detected many times during one instruction still produces a single report. Two retire ports can each retire one instruction per cycle and report on their own lanes. A flush input clears every pending entry. Each watchpoint has an enable that forwards its report to the fetch or load/store breakpoint request.

Top module: `wpg_top`

## Requirements
- R1: Fetch watchpoint i takes its selection from bits [i*N_FE +: N_FE] of `fw_sel`. With `fw_and[i]`=0 it fires when any selected fetch event is present. With `fw_and[i]`=1 it fires only when every selected event is present. It never fires when its selection is all zeros or when `fe_vld` is low.
- R2: The load/store event vector is {`ls_data`, `ls_addr`}, with the address events in the low bits. Load/store watchpoint j takes its selection from bits [j*N_LE +: N_LE] of `lw_sel` and combines it under `lw_and[j]` in the same way as R1, gated by `ls_vld`.
- R3: When bits [j*N_FW +: N_FW] of `lw_qual` are non-zero, load/store watchpoint j fires only if at least one of the selected fetch watchpoints is already pending for `ls_tag` or is being raised for that tag in the same cycle. A zero qualifier mask leaves the watchpoint unqualified.
- R4: A detected watchpoint produces no output while its instruction is in flight. When `ret_vld[p]` is high, lane p of `rpt_fw`/`rpt_lw` shows, on the next cycle, the watchpoints pending for `ret_tag[p*TAG_W +: TAG_W]`. In every other cycle the lane is zero.
- R5: Repeated detections of one watchpoint for one tag produce a single one-cycle report. Retiring the tag clears its entry, so a second retire of the same tag with no new events reports zero.
- R6: Both retire lanes work independently in the same cycle, each reporting its own tag's watchpoints.
- R7: An event for a tag that retires in the same cycle is included in that retirement's report and is not left behind in the table.
- R8: `flush` clears every table entry. Events presented in a flush cycle are dropped. A retirement in the flush cycle still reports what was stored.
- R9: `brk_fetch` is high in the cycle a report appears if any lane reports a fetch watchpoint whose bit in `fw_brk_en` is set. `brk_ls` does the same for load/store watchpoints and `lw_brk_en`.
- R10: After reset, all reports and both breakpoint outputs are zero and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_vld | input | 1 | Fetch match events valid |
| fe_ev | input | N_FE | Fetch comparator match events |
| fe_tag | input | TAG_W | Instruction tag of the fetch events |
| ls_vld | input | 1 | Load/store match events valid |
| ls_addr | input | N_LA | Load/store address comparator matches |
| ls_data | input | N_LD | Load/store data comparator matches |
| ls_tag | input | TAG_W | Instruction tag of the load/store events |
| flush | input | 1 | Discard all in-flight watchpoints |
| ret_vld | input | N_RET | Retire valid, one bit per lane |
| ret_tag | input | N_RET*TAG_W | Retiring tags, lane p in bits [p*TAG_W +: TAG_W] |
| fw_sel | input | N_FW*N_FE | Fetch watchpoint event selections |
| fw_and | input | N_FW | Fetch combine mode, 1 = AND, 0 = OR |
| fw_brk_en | input | N_FW | Forward fetch watchpoint to breakpoint |
| lw_sel | input | N_LW*N_LE | Load/store watchpoint event selections |
| lw_and | input | N_LW | Load/store combine mode, 1 = AND, 0 = OR |
| lw_qual | input | N_LW*N_FW | Qualifying fetch watchpoint masks |
| lw_brk_en | input | N_LW | Forward load/store watchpoint to breakpoint |
| rpt_fw | output | N_RET*N_FW | Reported fetch watchpoints per lane |
| rpt_lw | output | N_RET*N_LW | Reported load/store watchpoints per lane |
| brk_fetch | output | 1 | Fetch breakpoint request |
| brk_ls | output | 1 | Load/store breakpoint request |

## Verification
Two pairs of functions can collide in a single cycle. In the first, an event is detected for a tag in the same cycle that tag retires. In the second, a flush arrives together with a retirement and a new event. The bench drives the event and the retire in one cycle and expects the event to appear in that report and to be gone by the next retire of the tag. It then drives a flush alongside a retire and a fresh event. The retire must report only the stored bits, the fresh event must vanish, and the other flushed tags must later retire with empty reports.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic {
    COMB_OR  = 1'b0,
    COMB_AND = 1'b1
  } comb_mode_e;
endpackage

// File: rtl/wpg_andor.sv
module wpg_andor #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 2
) (
  input  logic                  ev_vld,
  input  logic [N_IN-1:0]       ev,
  input  logic [N_OUT*N_IN-1:0] sel,
  input  logic [N_OUT-1:0]      mode,
  output logic [N_OUT-1:0]      hit
);
  import wpg_pkg::*;

  for (genvar i = 0; i < N_OUT; i++) begin : g_term
    logic [N_IN-1:0] msk;
    logic            any_hit;
    logic            all_hit;
    assign msk = sel[i*N_IN +: N_IN];
    always_comb begin
      any_hit = |(ev & msk);
      all_hit = (msk != '0) && ((ev & msk) == msk);
      if (comb_mode_e'(mode[i]) == COMB_AND) hit[i] = ev_vld && all_hit;
      else                                    hit[i] = ev_vld && any_hit;
    end
  end
endmodule

// File: rtl/wpg_pend_table.sv
module wpg_pend_table #(
  parameter int TAG_W  = 3,
  parameter int W      = 4,
  parameter int LOOK_W = 2,
  parameter int N_RET  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   a_vld,
  input  logic [TAG_W-1:0]       a_tag,
  input  logic [W-1:0]           a_vec,
  input  logic                   b_vld,
  input  logic [TAG_W-1:0]       b_tag,
  input  logic [W-1:0]           b_vec,
  input  logic [N_RET-1:0]       ret_vld,
  input  logic [N_RET*TAG_W-1:0] ret_tag,
  input  logic [TAG_W-1:0]       look_tag,
  output logic [LOOK_W-1:0]      look_vec,
  output logic [N_RET*W-1:0]     ret_view
);
  localparam int DEPTH = 1 << TAG_W;

  logic [W-1:0] tab_q [DEPTH];
  logic [W-1:0] tab_d [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic retired;
    always_comb begin
      retired = 1'b0;
      for (int p = 0; p < N_RET; p++) begin
        if (ret_vld[p] && (ret_tag[p*TAG_W +: TAG_W] == TAG_W'(e))) retired = 1'b1;
      end
      tab_d[e] = tab_q[e];
      if (flush || retired) begin
        tab_d[e] = '0;
      end else begin
        if (a_vld && (a_tag == TAG_W'(e))) tab_d[e] = tab_d[e] | a_vec;
        if (b_vld && (b_tag == TAG_W'(e))) tab_d[e] = tab_d[e] | b_vec;
      end
    end
  end

  for (genvar p = 0; p < N_RET; p++) begin : g_view
    logic [TAG_W-1:0] t;
    assign t = ret_tag[p*TAG_W +: TAG_W];
    always_comb begin
      ret_view[p*W +: W] = tab_q[t];
      if (!flush) begin
        if (a_vld && (a_tag == t)) ret_view[p*W +: W] = ret_view[p*W +: W] | a_vec;
        if (b_vld && (b_tag == t)) ret_view[p*W +: W] = ret_view[p*W +: W] | b_vec;
      end
    end
  end

  always_comb look_vec = tab_q[look_tag][LOOK_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) tab_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) tab_q[e] <= tab_d[e];
    end
  end
endmodule

// File: rtl/wpg_top.sv
module wpg_top #(
  parameter int TAG_W = 3,
  parameter int N_FE  = 4,
  parameter int N_FW  = 2,
  parameter int N_LA  = 2,
  parameter int N_LD  = 2,
  parameter int N_LW  = 2,
  parameter int N_RET = 2,
  localparam int N_LE = N_LA + N_LD
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fe_vld,
  input  logic [N_FE-1:0]        fe_ev,
  input  logic [TAG_W-1:0]       fe_tag,
  input  logic                   ls_vld,
  input  logic [N_LA-1:0]        ls_addr,
  input  logic [N_LD-1:0]        ls_data,
  input  logic [TAG_W-1:0]       ls_tag,
  input  logic                   flush,
  input  logic [N_RET-1:0]       ret_vld,
  input  logic [N_RET*TAG_W-1:0] ret_tag,
  input  logic [N_FW*N_FE-1:0]   fw_sel,
  input  logic [N_FW-1:0]        fw_and,
  input  logic [N_FW-1:0]        fw_brk_en,
  input  logic [N_LW*N_LE-1:0]   lw_sel,
  input  logic [N_LW-1:0]        lw_and,
  input  logic [N_LW*N_FW-1:0]   lw_qual,
  input  logic [N_LW-1:0]        lw_brk_en,
  output logic [N_RET*N_FW-1:0]  rpt_fw,
  output logic [N_RET*N_LW-1:0]  rpt_lw,
  output logic                   brk_fetch,
  output logic                   brk_ls
);
  localparam int W = N_FW + N_LW;

  logic [N_FW-1:0]    fw_now;
  logic [N_LW-1:0]    lw_raw;
  logic [N_LW-1:0]    lw_now;
  logic [N_FW-1:0]    fw_stored;
  logic [N_FW-1:0]    fw_known;
  logic [N_RET*W-1:0] view;

  logic [N_RET*N_FW-1:0] rpt_fw_d, rpt_fw_q;
  logic [N_RET*N_LW-1:0] rpt_lw_d, rpt_lw_q;
  logic                  brk_f_d, brk_f_q, brk_l_d, brk_l_q;

  wpg_andor #(.N_IN(N_FE), .N_OUT(N_FW)) u_fe_andor (
    .ev_vld(fe_vld), .ev(fe_ev), .sel(fw_sel), .mode(fw_and), .hit(fw_now)
  );

  wpg_andor #(.N_IN(N_LE), .N_OUT(N_LW)) u_ls_andor (
    .ev_vld(ls_vld), .ev({ls_data, ls_addr}), .sel(lw_sel), .mode(lw_and), .hit(lw_raw)
  );

  // fetch watchpoints known for the load/store instruction: stored or arriving now
  always_comb begin
    fw_known = fw_stored;
    if (fe_vld && (fe_tag == ls_tag)) fw_known = fw_known | fw_now;
  end

  for (genvar j = 0; j < N_LW; j++) begin : g_qual
    logic [N_FW-1:0] qm;
    assign qm = lw_qual[j*N_FW +: N_FW];
    assign lw_now[j] = lw_raw[j] && ((qm == '0) || ((qm & fw_known) != '0));
  end

  wpg_pend_table #(.TAG_W(TAG_W), .W(W), .LOOK_W(N_FW), .N_RET(N_RET)) u_tab (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .a_vld(fe_vld), .a_tag(fe_tag), .a_vec({{N_LW{1'b0}}, fw_now}),
    .b_vld(ls_vld), .b_tag(ls_tag), .b_vec({lw_now, {N_FW{1'b0}}}),
    .ret_vld(ret_vld), .ret_tag(ret_tag),
    .look_tag(ls_tag), .look_vec(fw_stored), .ret_view(view)
  );

  always_comb begin
    brk_f_d = 1'b0;
    brk_l_d = 1'b0;
    for (int p = 0; p < N_RET; p++) begin
      rpt_fw_d[p*N_FW +: N_FW] = ret_vld[p] ? view[p*W +: N_FW] : '0;
      rpt_lw_d[p*N_LW +: N_LW] = ret_vld[p] ? view[p*W+N_FW +: N_LW] : '0;
      brk_f_d = brk_f_d | (|(rpt_fw_d[p*N_FW +: N_FW] & fw_brk_en));
      brk_l_d = brk_l_d | (|(rpt_lw_d[p*N_LW +: N_LW] & lw_brk_en));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_fw_q <= '0;
      rpt_lw_q <= '0;
      brk_f_q  <= 1'b0;
      brk_l_q  <= 1'b0;
    end else begin
      rpt_fw_q <= rpt_fw_d;
      rpt_lw_q <= rpt_lw_d;
      brk_f_q  <= brk_f_d;
      brk_l_q  <= brk_l_d;
    end
  end

  assign rpt_fw    = rpt_fw_q;
  assign rpt_lw    = rpt_lw_q;
  assign brk_fetch = brk_f_q;
  assign brk_ls    = brk_l_q;
endmodule

// File: rtl/wpg_chk.sv
module wpg_chk #(
  parameter int TAG_W = 3,
  parameter int N_FW  = 2,
  parameter int N_LW  = 2,
  parameter int N_RET = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fe_vld,
  input logic                   ls_vld,
  input logic                   flush,
  input logic [N_RET-1:0]       ret_vld,
  input logic [N_RET*TAG_W-1:0] ret_tag,
  input logic [N_RET*N_FW-1:0]  rpt_fw,
  input logic [N_RET*N_LW-1:0]  rpt_lw,
  input logic                   brk_fetch,
  input logic                   brk_ls
);
  for (genvar p = 0; p < N_RET; p++) begin : g_lane
    logic lane_busy;
    assign lane_busy = (rpt_fw[p*N_FW +: N_FW] != '0) || (rpt_lw[p*N_LW +: N_LW] != '0);

    AST_RPT_ONLY_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      lane_busy |-> $past(ret_vld[p])); // R4

    AST_SECOND_RETIRE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ret_vld[p]) && $past(ret_vld[p], 2) &&
       ($past(ret_tag[p*TAG_W +: TAG_W]) == $past(ret_tag[p*TAG_W +: TAG_W], 2)) &&
       !$past(fe_vld) && !$past(ls_vld)) |-> !lane_busy); // R5

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush, 2) && !$past(flush) && $past(ret_vld[p]) &&
       !$past(fe_vld) && !$past(ls_vld)) |-> !lane_busy); // R8
  end

  AST_BRK_FETCH_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_fetch |-> $past(ret_vld != '0)); // R9

  AST_BRK_LS_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ls |-> $past(ret_vld != '0)); // R9
endmodule

bind wpg_top wpg_chk #(.TAG_W(TAG_W), .N_FW(N_FW), .N_LW(N_LW), .N_RET(N_RET)) u_chk (
  .clk(clk), .rst_n(rst_n), .fe_vld(fe_vld), .ls_vld(ls_vld), .flush(flush),
  .ret_vld(ret_vld), .ret_tag(ret_tag), .rpt_fw(rpt_fw), .rpt_lw(rpt_lw),
  .brk_fetch(brk_fetch), .brk_ls(brk_ls)
);

// File: tb/wpg_top_tb.sv
`timescale 1ns/1ps
module wpg_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fe_vld;
  logic [3:0] fe_ev;
  logic [2:0] fe_tag;
  logic       ls_vld;
  logic [1:0] ls_addr, ls_data;
  logic [2:0] ls_tag;
  logic       flush;
  logic [1:0] ret_vld;
  logic [5:0] ret_tag;
  logic [7:0] fw_sel, lw_sel;
  logic [1:0] fw_and, fw_brk_en, lw_and, lw_brk_en;
  logic [3:0] lw_qual;
  logic [3:0] rpt_fw, rpt_lw;
  logic       brk_fetch, brk_ls;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  wpg_top u_dut (
    .clk(clk), .rst_n(rst_n), .fe_vld(fe_vld), .fe_ev(fe_ev), .fe_tag(fe_tag),
    .ls_vld(ls_vld), .ls_addr(ls_addr), .ls_data(ls_data), .ls_tag(ls_tag),
    .flush(flush), .ret_vld(ret_vld), .ret_tag(ret_tag),
    .fw_sel(fw_sel), .fw_and(fw_and), .fw_brk_en(fw_brk_en),
    .lw_sel(lw_sel), .lw_and(lw_and), .lw_qual(lw_qual), .lw_brk_en(lw_brk_en),
    .rpt_fw(rpt_fw), .rpt_lw(rpt_lw), .brk_fetch(brk_fetch), .brk_ls(brk_ls)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    fe_vld = 0; fe_ev = 0; fe_tag = 0;
    ls_vld = 0; ls_addr = 0; ls_data = 0; ls_tag = 0;
    flush = 0; ret_vld = 0; ret_tag = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic fetch(input logic [2:0] t, input logic [3:0] ev);
    fe_vld = 1; fe_tag = t; fe_ev = ev;
  endtask

  task automatic lsev(input logic [2:0] t, input logic [1:0] a, input logic [1:0] d);
    ls_vld = 1; ls_tag = t; ls_addr = a; ls_data = d;
  endtask

  task automatic retire(input int p, input logic [2:0] t);
    ret_vld[p] = 1'b1; ret_tag[p*3 +: 3] = t;
  endtask

  task automatic t_reset();
    chk("R10", "rpt_fw", 8'(rpt_fw), 8'h0);
    chk("R10", "rpt_lw", 8'(rpt_lw), 8'h0);
    chk("R10", "brk", 8'({brk_fetch, brk_ls}), 8'h0);
  endtask

  task automatic t_fetch_or();
    fetch(3'd1, 4'b0010); cyc();
    chk("R4", "pending not shown", 8'(rpt_fw), 8'h0);
    retire(0, 3'd1); cyc();
    chk("R1", "or fw lane0", 8'(rpt_fw[1:0]), 8'h1);
    chk("R4", "lane1 quiet", 8'(rpt_fw[3:2]), 8'h0);
    chk("R9", "brk_fetch", 8'(brk_fetch), 8'h1);
    cyc();
    chk("R4", "one-cycle report", 8'(rpt_fw), 8'h0);
  endtask

  task automatic t_fetch_and_two_lanes();
    fetch(3'd2, 4'b0100); cyc();
    fetch(3'd3, 4'b1100); cyc();
    retire(0, 3'd2); retire(1, 3'd3); cyc();
    chk("R1", "and partial", 8'(rpt_fw[1:0]), 8'h0);
    chk("R6", "and full lane1", 8'(rpt_fw[3:2]), 8'h2);
    chk("R9", "brk disabled wp", 8'(brk_fetch), 8'h0);
  endtask

  task automatic t_ls_qual();
    lsev(3'd4, 2'b01, 2'b01); cyc();
    fetch(3'd5, 4'b0001); cyc();
    lsev(3'd5, 2'b01, 2'b00); cyc();
    retire(0, 3'd4); retire(1, 3'd5); cyc();
    chk("R3", "unqualified blocked", 8'(rpt_lw[1:0]), 8'h2);
    chk("R2", "data event lw1", 8'(rpt_lw[1]), 8'h1);
    chk("R3", "qualified passes", 8'(rpt_lw[3:2]), 8'h1);
    chk("R6", "lane1 fw", 8'(rpt_fw[3:2]), 8'h1);
    chk("R9", "brk_ls", 8'(brk_ls), 8'h1);
  endtask

  task automatic t_dedup();
    for (int k = 0; k < 3; k++) begin lsev(3'd6, 2'b00, 2'b01); cyc(); end
    retire(0, 3'd6); cyc();
    chk("R5", "single report", 8'(rpt_lw[1:0]), 8'h2);
    chk("R9", "brk_ls off", 8'(brk_ls), 8'h0);
    cyc();
    chk("R5", "no repeat", 8'(rpt_lw), 8'h0);
    retire(0, 3'd6); cyc();
    chk("R5", "entry cleared", 8'(rpt_lw), 8'h0);
  endtask

  task automatic t_same_cycle();
    fetch(3'd7, 4'b0001); retire(0, 3'd7); cyc();
    chk("R7", "bypass report", 8'(rpt_fw[1:0]), 8'h1);
    chk("R9", "bypass brk", 8'(brk_fetch), 8'h1);
    retire(0, 3'd7); cyc();
    chk("R7", "not left behind", 8'(rpt_fw), 8'h0);
  endtask

  task automatic t_flush();
    fetch(3'd1, 4'b0001); cyc();
    fetch(3'd2, 4'b0001); cyc();
    flush = 1; retire(0, 3'd1); fetch(3'd3, 4'b0001); cyc();
    chk("R8", "retire in flush", 8'(rpt_fw[1:0]), 8'h1);
    retire(0, 3'd2); retire(1, 3'd3); cyc();
    chk("R8", "flushed entry", 8'(rpt_fw[1:0]), 8'h0);
    chk("R8", "dropped event", 8'(rpt_fw[3:2]), 8'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    fw_sel = {4'b1100, 4'b0011}; fw_and = 2'b10; fw_brk_en = 2'b01;
    lw_sel = {4'b0100, 4'b0001}; lw_and = 2'b00; lw_qual = {2'b00, 2'b01}; lw_brk_en = 2'b01;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    t_reset();
    t_fetch_or();
    t_fetch_and_two_lanes();
    t_ls_qual();
    t_dedup();
    t_same_cycle();
    t_flush();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule